// File: doc/BRIEF.md
# Display Controller Command Decoder

This block sits behind a two-wire serial slave front end and interprets the bytes it delivers for a page-organised monochrome display. The front end reports each received byte with a one-cycle valid strobe. It also reports bus start and bus stop events and read requests. The first byte after a start is a control byte. It chooses whether the bytes that follow are commands or pixel data.

In data mode each byte goes out on a single write port toward an external frame memory. That memory holds 8 pages of 132 column bytes. The byte is written at the current page and column, and the column then advances. In command mode one opcode is decoded and the block falls back to waiting for a new control byte. Opcodes can load the column pointer one nibble at a time, set the page, set the start line, or switch the mirror, inverse, force-all-on and display-enable flags. A group of analog setting opcodes is accepted, but the single argument byte that belongs to each of them is thrown away. Bad control bytes, unknown opcodes and read requests each raise a one-cycle error pulse.

Top module: `oled_cmd_decoder`

## Requirements
- R1: After reset all outputs are 0: no write, no error, page 0, column 0, start line 0, every display flag clear. The decoder waits for a control byte.
- R2: While waiting for a control byte, 0x80 enters command mode and 0x40 enters data mode. Any other byte leaves the decoder waiting and pulses `err_pulse` high for one cycle, in the cycle after the byte.
- R3: In data mode, a byte causes `mem_we` to be high for one cycle in the cycle after the byte. In that cycle `mem_addr` = page*132 + column and `mem_wdata` holds the byte. Data mode lasts until a bus event.
- R4: After each data write the column increments, but it stays at 131 once it has reached 131. A data byte arriving while the column is above 131 is dropped: there is no write and the column does not change.
- R5: After one opcode has been decoded in command mode, the decoder waits for a control byte again. For example, 0x40 sent after an opcode selects data mode and does not set the start line.
- R6: Opcodes 0x00–0x0F replace column bits [3:0] with opcode bits [3:0]. Opcodes 0x10–0x20 replace column bits [7:4] with opcode bits [3:0]. In both cases the other nibble is kept.
- R7: Opcodes 0x40–0x7F set the start line to opcode bits [5:0]. Opcodes 0xB0–0xBF set the page to opcode bits [2:0].
- R8: Opcode bit 0 gives the new flag value for these pairs: 0xA0/0xA1 for mirror, 0xA4/0xA5 for force-all-on, 0xA6/0xA7 for inverse, and 0xAE/0xAF for display enable.
- R9: Opcodes 0x81, 0xA8, 0xAD, 0xD3, 0xD5, 0xD8, 0xD9, 0xDA and 0xDB arm a skip. The next byte received in command mode is discarded with no effect, and the decoder then stays in command mode.
- R10: Opcodes 0xE3 and 0xC0–0xC8 change nothing and raise no error. Every opcode not listed in R6 to R10 pulses `err_pulse` and changes nothing else.
- R11: A bus start or stop returns the decoder to waiting for a control byte. A byte that arrives in the same cycle as such an event is ignored.
- R12: A read request pulses `err_pulse` in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_start | input | 1 | Bus start event strobe |
| bus_stop | input | 1 | Bus stop event strobe |
| rd_req | input | 1 | Read request strobe (unsupported) |
| rx_valid | input | 1 | Received byte strobe |
| rx_byte | input | 8 | Received byte |
| mem_we | output | 1 | Frame memory write enable |
| mem_addr | output | 11 | Frame memory byte address |
| mem_wdata | output | 8 | Frame memory write data |
| cur_page | output | 3 | Current page pointer |
| cur_col | output | 8 | Current column pointer |
| start_line | output | 6 | Display start line |
| disp_mirror | output | 1 | Mirror flag |
| force_all_on | output | 1 | Entire-display-on flag |
| disp_inverse | output | 1 | Inverse flag |
| disp_on | output | 1 | Display enable flag |
| err_pulse | output | 1 | One-cycle error pulse |

## Verification
An error in the mode or skip state shows up one cycle after the next byte. A data byte may appear as a write when it should not, a control byte may act as an opcode, or an expected error pulse may be missing. A column or page pointer that has gone wrong shows up at once on `cur_col` and `cur_page`, and again on `mem_addr` at the next data write. A skip flag that was lost or left set is caught on the byte right after the skip opcode, because that byte is chosen to change a visible flag if it were decoded.

// File: rtl/oled_pkg.sv
package oled_pkg;

    typedef enum logic [1:0] {
        M_IDLE = 2'd0,
        M_CMD  = 2'd1,
        M_DATA = 2'd2
    } mode_e;

    typedef enum logic [3:0] {
        OP_LOCOL,
        OP_HICOL,
        OP_START,
        OP_PAGE,
        OP_MIRROR,
        OP_ALLON,
        OP_INV,
        OP_DISP,
        OP_SKIP,
        OP_NOP,
        OP_BAD
    } op_kind_e;

endpackage

// File: rtl/oled_opcode_decode.sv
module oled_opcode_decode
    import oled_pkg::*;
(
    input  logic [7:0] op,
    output op_kind_e   kind
);
    always_comb begin
        if (op <= 8'h0F)                       kind = OP_LOCOL;
        else if (op <= 8'h20)                  kind = OP_HICOL;
        else if (op >= 8'h40 && op <= 8'h7F)   kind = OP_START;
        else if (op >= 8'hB0 && op <= 8'hBF)   kind = OP_PAGE;
        else if (op >= 8'hC0 && op <= 8'hC8)   kind = OP_NOP;
        else begin
            unique case (op)
                8'hA0, 8'hA1: kind = OP_MIRROR;
                8'hA4, 8'hA5: kind = OP_ALLON;
                8'hA6, 8'hA7: kind = OP_INV;
                8'hAE, 8'hAF: kind = OP_DISP;
                8'h81, 8'hA8, 8'hAD, 8'hD3, 8'hD5,
                8'hD8, 8'hD9, 8'hDA, 8'hDB: kind = OP_SKIP;
                8'hE3:        kind = OP_NOP;
                default:      kind = OP_BAD;
            endcase
        end
    end
endmodule

// File: rtl/oled_addr_gen.sv
module oled_addr_gen #(
    parameter int PAGES = 8,
    parameter int COLS  = 132,
    localparam int PAGE_W = $clog2(PAGES),
    localparam int ADDR_W = $clog2(PAGES * COLS)
) (
    input  logic [PAGE_W-1:0] page,
    input  logic [7:0]        col,
    output logic [ADDR_W-1:0] addr,
    output logic              in_range,
    output logic              at_last
);
    localparam logic [7:0] LAST_COL = 8'(COLS - 1);

    always_comb begin
        addr     = ADDR_W'(page) * ADDR_W'(COLS) + ADDR_W'(col);
        in_range = (col <= LAST_COL);
        at_last  = (col == LAST_COL);
    end
endmodule

// File: rtl/oled_cmd_decoder.sv
module oled_cmd_decoder
    import oled_pkg::*;
#(
    parameter int         PAGES    = 8,
    parameter int         COLS     = 132,
    parameter int         LINES    = 64,
    parameter logic [7:0] CMD_SEL  = 8'h80,
    parameter logic [7:0] DATA_SEL = 8'h40,
    localparam int PAGE_W = $clog2(PAGES),
    localparam int ADDR_W = $clog2(PAGES * COLS),
    localparam int SL_W   = $clog2(LINES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_start,
    input  logic              bus_stop,
    input  logic              rd_req,
    input  logic              rx_valid,
    input  logic [7:0]        rx_byte,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_wdata,
    output logic [PAGE_W-1:0] cur_page,
    output logic [7:0]        cur_col,
    output logic [SL_W-1:0]   start_line,
    output logic              disp_mirror,
    output logic              force_all_on,
    output logic              disp_inverse,
    output logic              disp_on,
    output logic              err_pulse
);

    typedef struct packed {
        mode_e             mode;
        logic              skip;
        logic [PAGE_W-1:0] page;
        logic [7:0]        col;
        logic [SL_W-1:0]   sline;
        logic              mirror;
        logic              all_on;
        logic              inverse;
        logic              enable;
        logic              we;
        logic [ADDR_W-1:0] addr;
        logic [7:0]        wdata;
        logic              err;
    } state_t;

    state_t state_d, state_q;

    op_kind_e          kind;
    logic [ADDR_W-1:0] wr_addr;
    logic              col_ok;
    logic              col_last;
    logic              bus_evt;

    oled_opcode_decode u_dec (
        .op   (rx_byte),
        .kind (kind)
    );

    oled_addr_gen #(
        .PAGES (PAGES),
        .COLS  (COLS)
    ) u_addr (
        .page     (state_q.page),
        .col      (state_q.col),
        .addr     (wr_addr),
        .in_range (col_ok),
        .at_last  (col_last)
    );

    assign bus_evt = bus_start | bus_stop;

    always_comb begin
        state_d     = state_q;
        state_d.we  = 1'b0;
        state_d.err = rd_req;
        if (bus_evt) begin
            state_d.mode = M_IDLE;
        end else if (rx_valid) begin
            unique case (state_q.mode)
                M_IDLE: begin
                    if (rx_byte == CMD_SEL)       state_d.mode = M_CMD;
                    else if (rx_byte == DATA_SEL) state_d.mode = M_DATA;
                    else                          state_d.err  = 1'b1;
                end
                M_DATA: begin
                    if (col_ok) begin
                        state_d.we    = 1'b1;
                        state_d.addr  = wr_addr;
                        state_d.wdata = rx_byte;
                        if (!col_last) state_d.col = state_q.col + 8'd1;
                    end
                end
                M_CMD: begin
                    if (state_q.skip) begin
                        state_d.skip = 1'b0;
                    end else begin
                        state_d.mode = M_IDLE;
                        unique case (kind)
                            OP_LOCOL:  state_d.col[3:0] = rx_byte[3:0];
                            OP_HICOL:  state_d.col[7:4] = rx_byte[3:0];
                            OP_START:  state_d.sline    = rx_byte[SL_W-1:0];
                            OP_PAGE:   state_d.page     = rx_byte[PAGE_W-1:0];
                            OP_MIRROR: state_d.mirror   = rx_byte[0];
                            OP_ALLON:  state_d.all_on   = rx_byte[0];
                            OP_INV:    state_d.inverse  = rx_byte[0];
                            OP_DISP:   state_d.enable   = rx_byte[0];
                            OP_SKIP:   state_d.skip     = 1'b1;
                            OP_NOP:    ;
                            default:   state_d.err      = 1'b1;
                        endcase
                    end
                end
                default: state_d.mode = M_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign mem_we       = state_q.we;
    assign mem_addr     = state_q.addr;
    assign mem_wdata    = state_q.wdata;
    assign cur_page     = state_q.page;
    assign cur_col      = state_q.col;
    assign start_line   = state_q.sline;
    assign disp_mirror  = state_q.mirror;
    assign force_all_on = state_q.all_on;
    assign disp_inverse = state_q.inverse;
    assign disp_on      = state_q.enable;
    assign err_pulse    = state_q.err;

endmodule

// File: rtl/oled_cmd_checker.sv
module oled_cmd_checker #(
    parameter int         COLS     = 132,
    parameter logic [7:0] CMD_SEL  = 8'h80,
    parameter logic [7:0] DATA_SEL = 8'h40
) (
    input logic       clk,
    input logic       rst_n,
    input logic       bus_start,
    input logic       bus_stop,
    input logic       rd_req,
    input logic       rx_valid,
    input logic [7:0] rx_byte,
    input logic       mem_we,
    input logic [7:0] cur_col,
    input logic       err_pulse,
    input logic [1:0] mode,
    input logic       skip
);
    localparam logic [7:0] LAST_COL = 8'(COLS - 1);

    logic ev;
    assign ev = bus_start | bus_stop;

    p_bad_sel_err_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && !ev && mode == 2'd0 && rx_byte != CMD_SEL && rx_byte != DATA_SEL)
        |=> err_pulse);

    p_we_from_data_r3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> $past(rx_valid && !ev && mode == 2'd2));

    p_col_hold_last_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && !ev && mode == 2'd2 && cur_col == LAST_COL) |=> cur_col == LAST_COL);

    p_cmd_to_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && !ev && mode == 2'd1 && !skip) |=> mode == 2'd0);

    p_skip_consume_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && !ev && mode == 2'd1 && skip) |=> (mode == 2'd1 && !skip && !err_pulse));

    p_event_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ev |=> (mode == 2'd0 && !mem_we));

    p_read_err_r12: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> err_pulse);

endmodule

bind oled_cmd_decoder oled_cmd_checker #(
    .COLS     (COLS),
    .CMD_SEL  (CMD_SEL),
    .DATA_SEL (DATA_SEL)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_start (bus_start),
    .bus_stop  (bus_stop),
    .rd_req    (rd_req),
    .rx_valid  (rx_valid),
    .rx_byte   (rx_byte),
    .mem_we    (mem_we),
    .cur_col   (cur_col),
    .err_pulse (err_pulse),
    .mode      (state_q.mode),
    .skip      (state_q.skip)
);

// File: tb/sim_oled_cmd_decoder.sv
`timescale 1ns/1ps
module sim_oled_cmd_decoder;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_start = 1'b0, bus_stop = 1'b0, rd_req = 1'b0;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_byte = 8'h00;
    logic        mem_we;
    logic [10:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic [2:0]  cur_page;
    logic [7:0]  cur_col;
    logic [5:0]  start_line;
    logic        disp_mirror, force_all_on, disp_inverse, disp_on, err_pulse;

    always #4 clk = ~clk;

    oled_cmd_decoder u0 (
        .clk(clk), .rst_n(rst_n), .bus_start(bus_start), .bus_stop(bus_stop),
        .rd_req(rd_req), .rx_valid(rx_valid), .rx_byte(rx_byte),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .cur_page(cur_page), .cur_col(cur_col), .start_line(start_line),
        .disp_mirror(disp_mirror), .force_all_on(force_all_on),
        .disp_inverse(disp_inverse), .disp_on(disp_on), .err_pulse(err_pulse)
    );

    int    checks = 0;
    int    fails  = 0;
    string cur_req = "R1";
    bit    started = 0;
    bit    done = 0;

    // behavioural reference: 0 waiting, 1 command, 2 data
    int m_mode, m_page, m_col, m_sl, m_addr, m_wd;
    bit m_skip, m_mir, m_on, m_inv, m_en, m_we, m_err;

    always @(posedge clk) begin
        started = 1;
        if (!rst_n) begin
            m_mode = 0; m_skip = 0; m_page = 0; m_col = 0; m_sl = 0;
            m_mir = 0; m_on = 0; m_inv = 0; m_en = 0;
            m_we = 0; m_err = 0; m_addr = 0; m_wd = 0;
        end else begin
            int b;
            b = int'(rx_byte);
            m_we = 0;
            m_err = rd_req;
            if (bus_start || bus_stop) m_mode = 0;
            else if (rx_valid) begin
                if (m_mode == 0) begin
                    if (b == 'h80) m_mode = 1;
                    else if (b == 'h40) m_mode = 2;
                    else m_err = 1;
                end else if (m_mode == 2) begin
                    if (m_col <= 131) begin
                        m_we = 1; m_addr = m_page * 132 + m_col; m_wd = b;
                        if (m_col < 131) m_col = m_col + 1;
                    end
                end else if (m_skip) begin
                    m_skip = 0;
                end else begin
                    m_mode = 0;
                    if (b <= 'h0F) m_col = (m_col & 'hF0) | (b & 'hF);
                    else if (b <= 'h20) m_col = (m_col & 'h0F) | ((b & 'hF) << 4);
                    else if (b >= 'h40 && b <= 'h7F) m_sl = b & 'h3F;
                    else if (b >= 'hB0 && b <= 'hBF) m_page = b & 7;
                    else if (b == 'hA0 || b == 'hA1) m_mir = b[0];
                    else if (b == 'hA4 || b == 'hA5) m_on = b[0];
                    else if (b == 'hA6 || b == 'hA7) m_inv = b[0];
                    else if (b == 'hAE || b == 'hAF) m_en = b[0];
                    else if (b == 'h81 || b == 'hA8 || b == 'hAD || b == 'hD3 || b == 'hD5 ||
                             b == 'hD8 || b == 'hD9 || b == 'hDA || b == 'hDB) m_skip = 1;
                    else if (b == 'hE3 || (b >= 'hC0 && b <= 'hC8)) ;
                    else m_err = 1;
                end
            end
        end
    end

    // per-cycle comparison against the reference, labelled with the active requirement
    always @(negedge clk) begin
        if (started && !done) begin
            bit bad;
            checks++;
            bad = (mem_we !== m_we) || (err_pulse !== m_err) ||
                  (int'(cur_page) != m_page) || (int'(cur_col) != m_col) ||
                  (int'(start_line) != m_sl) || (disp_mirror !== m_mir) ||
                  (force_all_on !== m_on) || (disp_inverse !== m_inv) || (disp_on !== m_en) ||
                  (m_we && ((int'(mem_addr) != m_addr) || (int'(mem_wdata) != m_wd)));
            if (bad) begin
                fails++;
                $display("FAIL %s model: act we=%0b err=%0b pg=%0d col=%0d sl=%0d flags=%0b%0b%0b%0b addr=%0d wd=%h exp we=%0b err=%0b pg=%0d col=%0d sl=%0d flags=%0b%0b%0b%0b addr=%0d wd=%h",
                    cur_req, mem_we, err_pulse, cur_page, cur_col, start_line,
                    disp_mirror, force_all_on, disp_inverse, disp_on, mem_addr, mem_wdata,
                    m_we, m_err, m_page, m_col, m_sl, m_mir, m_on, m_inv, m_en, m_addr, m_wd);
            end
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic send(input logic [7:0] b);
        @(negedge clk); rx_valid = 1'b1; rx_byte = b;
        @(negedge clk); rx_valid = 1'b0;
    endtask

    task automatic evt_stop();
        @(negedge clk); bus_stop = 1'b1;
        @(negedge clk); bus_stop = 1'b0;
    endtask

    task automatic cmd(input logic [7:0] b);
        send(8'h80); send(b);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        cur_req = "R1";
        chk("R1 we", int'(mem_we), 0);
        chk("R1 col", int'(cur_col), 0);
        chk("R1 flags", int'({disp_mirror, force_all_on, disp_inverse, disp_on, err_pulse}), 0);

        cur_req = "R2";
        cmd(8'hA7);       chk("R2 cmd select", int'(disp_inverse), 1);
        send(8'h55);      chk("R2 bad selector err", int'(err_pulse), 1);
        send(8'h40); send(8'h3C);
        chk("R2 data select we", int'(mem_we), 1);
        chk("R2 data byte", int'(mem_wdata), 'h3C);
        evt_stop();

        cur_req = "R7";
        cmd(8'hBE);       chk("R7 page", int'(cur_page), 6);
        cmd(8'hB3);       chk("R7 page", int'(cur_page), 3);
        cmd(8'h45);       chk("R7 start line", int'(start_line), 5);

        cur_req = "R6";
        cmd(8'h05);       chk("R6 low nibble", int'(cur_col), 5);
        cmd(8'h18);       chk("R6 high nibble", int'(cur_col), 'h85);
        cmd(8'h10);       chk("R6 high nibble clear", int'(cur_col), 5);
        cmd(8'h1A); cmd(8'h20);
        chk("R6 opcode 0x20", int'(cur_col), 5);

        cur_req = "R3";
        send(8'h40); send(8'hAA);
        chk("R3 we", int'(mem_we), 1);
        chk("R3 addr", int'(mem_addr), 3 * 132 + 5);
        chk("R3 data", int'(mem_wdata), 'hAA);
        send(8'h55);      chk("R3 next addr", int'(mem_addr), 3 * 132 + 6);
        evt_stop();

        cur_req = "R4";
        cmd(8'h02); cmd(8'h18);
        chk("R4 col set", int'(cur_col), 130);
        send(8'h40); send(8'h11); send(8'h22);
        chk("R4 col at last", int'(cur_col), 131);
        send(8'h33);
        chk("R4 saturate addr", int'(mem_addr), 3 * 132 + 131);
        chk("R4 saturate col", int'(cur_col), 131);
        evt_stop();
        cmd(8'h0F);
        send(8'h40); send(8'h44);
        chk("R4 out of range no write", int'(mem_we), 0);
        chk("R4 out of range col", int'(cur_col), 'h8F);
        evt_stop();

        cur_req = "R5";
        cmd(8'h00); cmd(8'h10);
        cmd(8'hA6);
        send(8'h40); send(8'h77);
        chk("R5 0x40 after opcode is selector", int'(mem_we), 1);
        chk("R5 start line untouched", int'(start_line), 5);
        evt_stop();

        cur_req = "R8";
        cmd(8'hA1);       chk("R8 mirror on", int'(disp_mirror), 1);
        cmd(8'hA0);       chk("R8 mirror off", int'(disp_mirror), 0);
        cmd(8'hA5);       chk("R8 all on", int'(force_all_on), 1);
        cmd(8'hA4);       chk("R8 all off", int'(force_all_on), 0);
        cmd(8'hAF);       chk("R8 display on", int'(disp_on), 1);
        cmd(8'hAE);       chk("R8 display off", int'(disp_on), 0);
        cmd(8'hAF);
        cmd(8'hA7);       chk("R8 inverse on", int'(disp_inverse), 1);

        cur_req = "R9";
        cmd(8'h81);
        cmd(8'hA6);       chk("R9 argument discarded", int'(disp_inverse), 1);
        send(8'hA6);      chk("R9 still command mode", int'(disp_inverse), 0);
        cmd(8'hD8);
        cmd(8'hA5);       chk("R9 argument discarded", int'(force_all_on), 0);
        send(8'hA5);      chk("R9 still command mode", int'(force_all_on), 1);
        cmd(8'hA4);

        cur_req = "R10";
        cmd(8'hE3);       chk("R10 nop no err", int'(err_pulse), 0);
        cmd(8'hC4);       chk("R10 ignored no err", int'(err_pulse), 0);
        cmd(8'hC9);       chk("R10 unknown err", int'(err_pulse), 1);
        cmd(8'hA2);       chk("R10 unknown err", int'(err_pulse), 1);
        cmd(8'h21);       chk("R10 unknown err", int'(err_pulse), 1);
        chk("R10 col kept", int'(cur_col), 1);

        cur_req = "R11";
        send(8'h40); evt_stop();
        send(8'h99);
        chk("R11 stop returns to wait", int'(err_pulse), 1);
        chk("R11 no write", int'(mem_we), 0);
        send(8'h40);
        @(negedge clk); bus_start = 1'b1; rx_valid = 1'b1; rx_byte = 8'h80;
        @(negedge clk); bus_start = 1'b0; rx_valid = 1'b0;
        chk("R11 byte with event ignored", int'(mem_we), 0);
        send(8'hA7);
        chk("R11 next is selector", int'(err_pulse), 1);
        chk("R11 inverse untouched", int'(disp_inverse), 0);

        cur_req = "R12";
        @(negedge clk); rd_req = 1'b1;
        @(negedge clk); rd_req = 1'b0;
        chk("R12 read err", int'(err_pulse), 1);
        @(negedge clk);
        chk("R12 err one cycle", int'(err_pulse), 0);

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; fails++;
            $display("FAIL watchdog %s: actual=timeout expected=completion", cur_req);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule